// File: doc/BRIEF.md
# SDRAM Bank Precharge State Tracker

This block sits between a memory controller's scheduler and the SDRAM command pins. It keeps, for every bank, whether a row is open and whether the bank is still recovering from a precharge. Each cycle it takes at most one request: open a row, read, write, or precharge. A request is turned into a registered command with its address and bank-select pins, or it is held back with a stall, or it is refused with an error pulse.

A precharge request names one bank or asks for every bank. The single-bank form drives the auto-precharge/all-banks address bit low and puts the chosen bank on the bank-select pins. The all-bank form drives that bit high and forces the bank-select pins to zero, because the memory ignores them in that case. Every bank that a precharge touches becomes idle and loads its own recovery counter. It cannot be opened again until the precharge-to-activate time, given in clock cycles by `T_RP`, has passed since the precharge command. An open request to a recovering bank is stalled so that the scheduler retries it. A read or write to a bank with no open row is refused with a one-cycle error pulse and produces no command.

Top module: `sdram_pre_tracker`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the command pins show NOP, `err_pulse` is low, and `bank_open` and `bank_busy` are all zero.
- R2: An open request (`req_op`=0) to a bank that is idle and not recovering produces, one cycle later, the pins CS#,RAS#,CAS#,WE# = L,L,H,H with the row on `cmd_addr` and the bank on `cmd_ba`, and sets that bank's `bank_open` bit.
- R3: A precharge request (`req_op`=3) with `req_all` low produces pins L,L,H,L, address bit `A10_BIT` low and all other address bits zero, and `cmd_ba` equal to the requested bank. Only that bank is closed.
- R4: A precharge request with `req_all` high produces pins L,L,H,L, address bit `A10_BIT` high and all other address bits zero, and `cmd_ba` = 0 whatever bank is requested. Every bank is closed.
- R5: A precharged bank shows `bank_busy` for `T_RP`-1 cycles after the precharge command. An open request to it in that window raises `req_stall` in the same cycle and yields neither a command nor an error. The earliest open command follows the precharge command by exactly `T_RP` cycles.
- R6: A read (`req_op`=1) or write (`req_op`=2) to an open bank produces pins L,H,L,H or L,H,L,L respectively, the column on `cmd_addr` with bit `A10_BIT` forced low, and the bank on `cmd_ba`.
- R7: A read or write to a bank with no open row raises `err_pulse` for exactly the next cycle, outputs NOP, and leaves every bank's state unchanged.
- R8: An open request to a bank that already has an open row raises `err_pulse` on the next cycle and is not issued.
- R9: A cycle without an issued request outputs NOP (CS# low, RAS#, CAS#, WE# high) with `cmd_addr` and `cmd_ba` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | 0 open row, 1 read, 2 write, 3 precharge |
| req_all | input | 1 | Precharge every bank (precharge only) |
| req_bank | input | BA_W (2) | Target bank |
| req_addr | input | ADDR_W (12) | Row for open, column for read/write |
| req_stall | output | 1 | Open request held back, retry later |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_addr | output | ADDR_W (12) | Address pins |
| cmd_ba | output | BA_W (2) | Bank-select pins |
| bank_open | output | NUM_BANKS (4) | Per-bank row-open flag |
| bank_busy | output | NUM_BANKS (4) | Per-bank precharge recovery in progress |
| err_pulse | output | 1 | Illegal request refused, one cycle |

## Verification
A wrong open flag appears one cycle after the next read, write or open request to that bank. A request that should pass then shows as an error pulse, or a refused one shows as a command on the pins. A recovery counter that is loaded wrongly or decrements wrongly moves the cycle where `req_stall` drops, so the open command arrives one cycle early or late against the precharge command. The stimulus places open requests on every cycle of the recovery window to expose that. A wrong decode of the all-bank bit shows on the very next cycle as nonzero bank-select pins, or as a bank that stays open and later accepts a read it should refuse.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

   typedef enum logic [1:0] {
      OP_ACT   = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2,
      OP_PRE   = 2'd3
   } req_op_e;

   typedef enum logic [2:0] {
      K_NOP,
      K_ACT,
      K_RD,
      K_WR,
      K_PRE
   } cmd_kind_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } cmd_pins_t;

   localparam cmd_pins_t PINS_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam cmd_pins_t PINS_ACT = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
   localparam cmd_pins_t PINS_RD  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
   localparam cmd_pins_t PINS_WR  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
   localparam cmd_pins_t PINS_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};

endpackage

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer #(
   parameter int T_RP = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pre_hit,
   input  logic act_hit,
   output logic is_open,
   output logic is_busy
);
   localparam int CNT_W = (T_RP < 2) ? 1 : $clog2(T_RP);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(T_RP - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             open_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         open_q <= 1'b0;
      end else if (pre_hit) begin
         cnt_q  <= LOAD;
         open_q <= 1'b0;
      end else begin
         if (act_hit)
            open_q <= 1'b1;
         if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
      end
   end

   assign is_open = open_q;
   assign is_busy = (cnt_q != '0);
endmodule

// File: rtl/sdram_cmd_encode.sv
module sdram_cmd_encode
   import sdram_trk_pkg::*;
(
   input  cmd_kind_e kind,
   output cmd_pins_t pins
);
   always_comb begin
      case (kind)
         K_ACT:   pins = PINS_ACT;
         K_RD:    pins = PINS_RD;
         K_WR:    pins = PINS_WR;
         K_PRE:   pins = PINS_PRE;
         default: pins = PINS_NOP;
      endcase
   end
endmodule

// File: rtl/sdram_addr_mux.sv
module sdram_addr_mux
   import sdram_trk_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int BA_W    = 2,
   parameter int A10_BIT = 10
) (
   input  cmd_kind_e         kind,
   input  logic              all_i,
   input  logic [BA_W-1:0]   bank_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BA_W-1:0]   ba_o
);
   always_comb begin
      addr_o = '0;
      ba_o   = '0;
      case (kind)
         K_ACT: begin
            addr_o = addr_i;
            ba_o   = bank_i;
         end
         K_RD, K_WR: begin
            addr_o          = addr_i;
            addr_o[A10_BIT] = 1'b0;
            ba_o            = bank_i;
         end
         K_PRE: begin
            addr_o[A10_BIT] = all_i;
            ba_o            = all_i ? '0 : bank_i;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/sdram_pre_tracker.sv
module sdram_pre_tracker
   import sdram_trk_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 12,
   parameter int A10_BIT   = 10,
   parameter int T_RP      = 3,
   localparam int BA_W     = (NUM_BANKS < 2) ? 1 : $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [1:0]           req_op,
   input  logic                 req_all,
   input  logic [BA_W-1:0]      req_bank,
   input  logic [ADDR_W-1:0]    req_addr,
   output logic                 req_stall,
   output logic                 cmd_cs_n,
   output logic                 cmd_ras_n,
   output logic                 cmd_cas_n,
   output logic                 cmd_we_n,
   output logic [ADDR_W-1:0]    cmd_addr,
   output logic [BA_W-1:0]      cmd_ba,
   output logic [NUM_BANKS-1:0] bank_open,
   output logic [NUM_BANKS-1:0] bank_busy,
   output logic                 err_pulse
);
   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (A10_BIT >= ADDR_W) begin : g_bad_a10
      $error("A10_BIT must lie inside the address bus");
   end
   if (T_RP < 1) begin : g_bad_trp
      $error("T_RP must be at least one cycle");
   end

   req_op_e   op_e;
   cmd_kind_e kind;
   logic      err_d;
   logic      sel_open;
   logic      sel_busy;

   logic [NUM_BANKS-1:0] pre_hit;
   logic [NUM_BANKS-1:0] act_hit;

   assign op_e     = req_op_e'(req_op);
   assign sel_open = bank_open[req_bank];
   assign sel_busy = bank_busy[req_bank];

   always_comb begin
      kind      = K_NOP;
      req_stall = 1'b0;
      err_d     = 1'b0;
      if (req_valid) begin
         case (op_e)
            OP_ACT: begin
               if (sel_busy)      req_stall = 1'b1;
               else if (sel_open) err_d     = 1'b1;
               else               kind      = K_ACT;
            end
            OP_READ: begin
               if (sel_open) kind  = K_RD;
               else          err_d = 1'b1;
            end
            OP_WRITE: begin
               if (sel_open) kind  = K_WR;
               else          err_d = 1'b1;
            end
            default: kind = K_PRE;
         endcase
      end
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign pre_hit[b] = (kind == K_PRE) && (req_all || (req_bank == BA_W'(b)));
      assign act_hit[b] = (kind == K_ACT) && (req_bank == BA_W'(b));

      sdram_bank_timer #(.T_RP(T_RP)) u_timer (
         .clk     (clk),
         .rst_n   (rst_n),
         .pre_hit (pre_hit[b]),
         .act_hit (act_hit[b]),
         .is_open (bank_open[b]),
         .is_busy (bank_busy[b])
      );
   end

   cmd_pins_t         pins_d;
   logic [ADDR_W-1:0] addr_d;
   logic [BA_W-1:0]   ba_d;

   sdram_cmd_encode u_enc (
      .kind (kind),
      .pins (pins_d)
   );

   sdram_addr_mux #(
      .ADDR_W  (ADDR_W),
      .BA_W    (BA_W),
      .A10_BIT (A10_BIT)
   ) u_amux (
      .kind   (kind),
      .all_i  (req_all),
      .bank_i (req_bank),
      .addr_i (req_addr),
      .addr_o (addr_d),
      .ba_o   (ba_d)
   );

   cmd_pins_t pins_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pins_q    <= PINS_NOP;
         cmd_addr  <= '0;
         cmd_ba    <= '0;
         err_pulse <= 1'b0;
      end else begin
         pins_q    <= pins_d;
         cmd_addr  <= addr_d;
         cmd_ba    <= ba_d;
         err_pulse <= err_d;
      end
   end

   assign cmd_cs_n  = pins_q.cs_n;
   assign cmd_ras_n = pins_q.ras_n;
   assign cmd_cas_n = pins_q.cas_n;
   assign cmd_we_n  = pins_q.we_n;
endmodule

// File: rtl/sdram_pre_tracker_chk.sv
module sdram_pre_tracker_chk #(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 12,
   parameter int A10_BIT   = 10,
   parameter int BA_W      = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic [1:0]           req_op,
   input logic [BA_W-1:0]      req_bank,
   input logic                 req_stall,
   input logic                 cmd_cs_n,
   input logic                 cmd_ras_n,
   input logic                 cmd_cas_n,
   input logic                 cmd_we_n,
   input logic [ADDR_W-1:0]    cmd_addr,
   input logic [BA_W-1:0]      cmd_ba,
   input logic [NUM_BANKS-1:0] bank_open,
   input logic [NUM_BANKS-1:0] bank_busy,
   input logic                 err_pulse
);
   logic [3:0] pins;
   assign pins = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};

   assert_act_marks_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pins == 4'b0011) |-> bank_open[cmd_ba]);

   assert_pre_all_ba_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pins == 4'b0010 && cmd_addr[A10_BIT]) |-> (cmd_ba == '0 && bank_open == '0));

   assert_stall_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_stall |-> (bank_busy[req_bank] && !bank_open[req_bank]));

   assert_stall_no_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'd0 && req_stall) |=> (pins == 4'b0111 && !err_pulse));

   assert_rw_a10_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pins == 4'b0101 || pins == 4'b0100) |-> !cmd_addr[A10_BIT]);

   assert_err_no_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> (pins == 4'b0111));

   assert_nop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pins == 4'b0111) |-> (cmd_addr == '0 && cmd_ba == '0));
endmodule

bind sdram_pre_tracker sdram_pre_tracker_chk #(
   .NUM_BANKS (NUM_BANKS),
   .ADDR_W    (ADDR_W),
   .A10_BIT   (A10_BIT),
   .BA_W      (BA_W)
) u_chk (.*);

// File: tb/sdram_pre_tracker_tb.sv
`timescale 1ns/1ps
module sdram_pre_tracker_tb;
   localparam int NB = 4;
   localparam int AW = 12;
   localparam int BW = 2;
   localparam int NV = 15;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = '0;
   logic          req_all = 1'b0;
   logic [BW-1:0] req_bank = '0;
   logic [AW-1:0] req_addr = '0;
   logic          req_stall;
   logic          cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
   logic [AW-1:0] cmd_addr;
   logic [BW-1:0] cmd_ba;
   logic [NB-1:0] bank_open, bank_busy;
   logic          err_pulse;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   always #2.5 clk = ~clk;

   sdram_pre_tracker #(.NUM_BANKS(NB), .ADDR_W(AW), .A10_BIT(10), .T_RP(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_all(req_all), .req_bank(req_bank), .req_addr(req_addr),
      .req_stall(req_stall), .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n),
      .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cmd_addr(cmd_addr),
      .cmd_ba(cmd_ba), .bank_open(bank_open), .bank_busy(bank_busy),
      .err_pulse(err_pulse));

   // {valid, op, all, bank, addr, exp_pins, exp_a10, exp_ba, exp_err, exp_stall}
   localparam logic [26:0] VEC [NV] = '{
      {1'b1, 2'd0, 1'b0, 2'd0, 12'h123, 4'b0011, 1'b0, 2'd0, 1'b0, 1'b0},
      {1'b1, 2'd1, 1'b0, 2'd0, 12'h405, 4'b0101, 1'b0, 2'd0, 1'b0, 1'b0},
      {1'b1, 2'd2, 1'b0, 2'd1, 12'h010, 4'b0111, 1'b0, 2'd0, 1'b1, 1'b0},
      {1'b1, 2'd0, 1'b0, 2'd1, 12'h400, 4'b0011, 1'b1, 2'd1, 1'b0, 1'b0},
      {1'b1, 2'd2, 1'b0, 2'd1, 12'h010, 4'b0100, 1'b0, 2'd1, 1'b0, 1'b0},
      {1'b1, 2'd3, 1'b0, 2'd0, 12'h7FF, 4'b0010, 1'b0, 2'd0, 1'b0, 1'b0},
      {1'b1, 2'd0, 1'b0, 2'd0, 12'h055, 4'b0111, 1'b0, 2'd0, 1'b0, 1'b1},
      {1'b1, 2'd0, 1'b0, 2'd0, 12'h055, 4'b0111, 1'b0, 2'd0, 1'b0, 1'b1},
      {1'b1, 2'd0, 1'b0, 2'd0, 12'h055, 4'b0011, 1'b0, 2'd0, 1'b0, 1'b0},
      {1'b1, 2'd3, 1'b1, 2'd3, 12'h000, 4'b0010, 1'b1, 2'd0, 1'b0, 1'b0},
      {1'b1, 2'd1, 1'b0, 2'd1, 12'h020, 4'b0111, 1'b0, 2'd0, 1'b1, 1'b0},
      {1'b0, 2'd0, 1'b0, 2'd0, 12'h000, 4'b0111, 1'b0, 2'd0, 1'b0, 1'b0},
      {1'b1, 2'd0, 1'b0, 2'd2, 12'h3C4, 4'b0011, 1'b0, 2'd2, 1'b0, 1'b0},
      {1'b1, 2'd0, 1'b0, 2'd2, 12'h3C4, 4'b0111, 1'b0, 2'd0, 1'b1, 1'b0},
      {1'b1, 2'd1, 1'b0, 2'd2, 12'h7FF, 4'b0101, 1'b0, 2'd2, 1'b0, 1'b0}
   };

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(input logic v, input logic [1:0] op, input logic all,
                                    input logic err, input logic stall);
      if (!v)            return "R9";
      if (stall)         return "R5";
      if (err && op == 0) return "R8";
      if (err)           return "R7";
      case (op)
         2'd0:    return "R2";
         2'd1, 2'd2: return "R6";
         default: return all ? "R4" : "R3";
      endcase
   endfunction

   function automatic logic [AW-1:0] exp_addr(input logic [3:0] p, input logic [AW-1:0] a,
                                              input logic a10);
      case (p)
         4'b0011:          return a;
         4'b0101, 4'b0100: return a & ~(AW'(1) << 10);
         4'b0010:          return AW'(a10) << 10;
         default:          return '0;
      endcase
   endfunction

   function automatic logic [3:0] pins();
      return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
   endfunction

   task automatic drive(input logic v, input logic [1:0] op, input logic all,
                        input logic [1:0] bank, input logic [AW-1:0] addr);
      req_valid = v; req_op = op; req_all = all; req_bank = bank; req_addr = addr;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #100000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(pins() == 4'b0111, "R1", "pins in reset", 32'(pins()), 32'h7);
      check(bank_open == '0 && bank_busy == '0, "R1", "status in reset",
            32'({bank_open, bank_busy}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(pins() == 4'b0111 && !err_pulse, "R1", "first cycle after reset",
            32'({err_pulse, pins()}), 32'h7);
      check(bank_open == '0 && bank_busy == '0, "R1", "status after reset",
            32'({bank_open, bank_busy}), 0);

      // table walk, one request per cycle
      for (int i = 0; i < NV; i++) begin
         logic [26:0] e;
         string t;
         e = VEC[i];
         t = tag_of(e[26], e[25:24], e[23], e[1], e[0]);
         drive(e[26], e[25:24], e[23], e[22:21], e[20:9]);
         #1;
         check(req_stall == e[0], t, $sformatf("vec %0d stall", i), 32'(req_stall), 32'(e[0]));
         @(negedge clk);
         check(pins() == e[8:5], t, $sformatf("vec %0d pins", i), 32'(pins()), 32'(e[8:5]));
         check(cmd_addr == exp_addr(e[8:5], e[20:9], e[4]), t, $sformatf("vec %0d addr", i),
               32'(cmd_addr), 32'(exp_addr(e[8:5], e[20:9], e[4])));
         check(cmd_ba == e[3:2], t, $sformatf("vec %0d ba", i), 32'(cmd_ba), 32'(e[3:2]));
         check(err_pulse == e[1], t, $sformatf("vec %0d err", i), 32'(err_pulse), 32'(e[1]));
      end

      // R4: all-bank precharge closed bank 0; bank 2 reopened afterwards
      drive(1'b0, 2'd0, 1'b0, 2'd0, '0);
      check(bank_open == 4'b0100, "R4", "open set after all-bank precharge",
            32'(bank_open), 32'h4);
      // R7: refused request left state untouched and error did not linger
      check(!err_pulse, "R7", "error lasts one cycle", 32'(err_pulse), 0);

      // R3 / R5: single precharge of bank 2, then recovery window
      drive(1'b1, 2'd3, 1'b0, 2'd2, 12'hFFF);
      @(negedge clk);
      drive(1'b0, 2'd0, 1'b0, 2'd0, '0);
      check(bank_open == 4'b0000, "R3", "bank closed by single precharge",
            32'(bank_open), 0);
      check(bank_busy == 4'b0100, "R5", "busy right after precharge",
            32'(bank_busy), 32'h4);
      @(negedge clk);
      check(bank_busy == 4'b0100, "R5", "busy second cycle", 32'(bank_busy), 32'h4);
      @(negedge clk);
      check(bank_busy == 4'b0000, "R5", "busy cleared", 32'(bank_busy), 0);

      // R1: reset in the middle of operation
      drive(1'b1, 2'd0, 1'b0, 2'd3, 12'h111);
      @(negedge clk);
      drive(1'b0, 2'd0, 1'b0, 2'd0, '0);
      check(bank_open == 4'b1000, "R2", "bank 3 opened", 32'(bank_open), 32'h8);
      rst_n = 1'b0;
      @(negedge clk);
      check(bank_open == '0 && pins() == 4'b0111, "R1", "reset clears open rows",
            32'({bank_open, pins()}), 32'h7);
      rst_n = 1'b1;
      @(negedge clk);

      finish_run();
   end
endmodule